// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a binary up-counter built from identical small counting stages that all share one clock, so every bit of the count changes on the same rising edge. Two enables control counting. Both must be high for the count to advance. Only the second enable, the carry-enable, is passed along the chain of stages as a look-ahead carry. Each stage's carry output feeds the carry-enable of the stage above it, so a wide counter needs no extra gating between stages.

The counter can be preset. While the active-low load input is low, the next rising edge copies the data word into the count, whatever the enables are doing. An active-low clear acts at once, without waiting for a clock edge, and overrides everything else. The top-level carry output rises while the count is at its all-ones value and the carry-enable is high. That output can feed a further counter, or serve as a terminal-count strobe one count period long.

Top module: `casc_counter`

## Requirements
- R1: While clr_n is low, count is zero. It goes to zero as soon as clr_n falls, without waiting for a clock edge.
- R2: Clear overrides load and counting. An edge that occurs while clr_n is low leaves count at zero, even with load_n low or both enables high.
- R3: When load_n is low at a rising edge, count takes the value of data on that edge, whatever the levels of enable_p and enable_t.
- R4: When load_n is high and enable_p and enable_t are both high, each rising edge adds one to count.
- R5: When load_n is high and either enable is low, count keeps its value across the edge.
- R6: From the all-ones value (2^CNT_W - 1), a counting edge takes count to zero.
- R7: carry_out is high exactly when enable_t is high and count is all ones. It follows enable_t at once, with no clock edge, and does not depend on enable_p.
- R8: When a 4-bit stage passes from 15 to 0, the stage above it advances on the same edge. For example, count 0x0F becomes 0x10 and 0xEF becomes 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| enable_p | input | 1 | Count enable that does not affect the carry |
| enable_t | input | 1 | Count enable that also gates the carry chain |
| data | input | CNT_W | Preset value copied in by a load |
| count | output | CNT_W | Current count |
| carry_out | output | 1 | High when enable_t is high and count is all ones |

## Verification
A behavioural integer model runs beside the counter. The counter is driven with long counting runs, runs broken up by either enable going low, loads with the enables low and with them high, and clears that arrive in the middle of a cycle while a load or a count is pending. The long runs pass every low-nibble rollover and the full 8-bit wrap, which separates a true look-ahead chain from stages that advance on their own. Toggling enable_t and enable_p separately at the all-ones value tells the carry gating apart from the count gating. The mid-cycle clears show that the clear is asynchronous and that it overrides a load.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;

  parameter int STAGE_W = 4;

  typedef logic [STAGE_W-1:0] stage_t;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_COUNT = 2'd2
  } cnt_mode_e;

  // next value of a stage when it advances, wrapping at all ones
  function automatic stage_t stage_inc(stage_t q);
    return q + stage_t'(1);
  endfunction

  // stage sits at its terminal value
  function automatic logic stage_full(stage_t q);
    return &q;
  endfunction

endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import casc_counter_pkg::*;
(
  input  logic      ld_n,
  input  logic      en_p,
  input  logic      en_t,
  output cnt_mode_e mode
);

  logic load_req;
  logic count_req;

  assign load_req  = !ld_n;
  assign count_req = en_p && en_t;

  // load wins over counting; otherwise hold
  always_comb begin
    if (load_req)       mode = MODE_LOAD;
    else if (count_req) mode = MODE_COUNT;
    else                mode = MODE_HOLD;
  end

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import casc_counter_pkg::*;
(
  input  logic   clk,
  input  logic   clr_n,
  input  logic   ld_n,
  input  logic   en_p,
  input  logic   en_t,
  input  stage_t d,
  output stage_t q,
  output logic   rco
);

  cnt_mode_e mode;
  stage_t    q_next;

  cnt_mode_dec u_dec (
    .ld_n (ld_n),
    .en_p (en_p),
    .en_t (en_t),
    .mode (mode)
  );

  always_comb begin
    case (mode)
      MODE_LOAD:  q_next = d;
      MODE_COUNT: q_next = stage_inc(q);
      default:    q_next = q;
    endcase
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_next;
  end

  // look-ahead carry: purely combinational, gated only by en_t
  assign rco = en_t && stage_full(q);

endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import casc_counter_pkg::*;
#(
  parameter int NSTAGES = 2,
  localparam int CNT_W  = NSTAGES * STAGE_W
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             enable_p,
  input  logic             enable_t,
  input  logic [CNT_W-1:0] data,
  output logic [CNT_W-1:0] count,
  output logic             carry_out
);

  // carry-enable seen by each stage; index NSTAGES is the final carry
  logic [NSTAGES:0] stage_en_t;

  assign stage_en_t[0] = enable_t;

  for (genvar k = 0; k < NSTAGES; k++) begin : g_stage
    stage_t d_k;
    stage_t q_k;

    assign d_k = data[k*STAGE_W +: STAGE_W];
    assign count[k*STAGE_W +: STAGE_W] = q_k;

    cnt_stage u_stage (
      .clk  (clk),
      .clr_n(clr_n),
      .ld_n (load_n),
      .en_p (enable_p),
      .en_t (stage_en_t[k]),
      .d    (d_k),
      .q    (q_k),
      .rco  (stage_en_t[k+1])
    );
  end

  assign carry_out = stage_en_t[NSTAGES];

endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          clr_n,
  input logic          load_n,
  input logic          enable_p,
  input logic          enable_t,
  input logic [CW-1:0] data,
  input logic [CW-1:0] count,
  input logic          carry_out
);

  // R1: count reads zero at any edge while clear is held
  a_r1_clear_zero: assert property (@(posedge clk)
    !clr_n |-> count == '0);

  // R3: load copies the data word regardless of enables
  a_r3_load_data: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(data));

  // R4: both enables high and no load advances by one
  a_r4_count_up: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && enable_p && enable_t) |=> count == CW'($past(count) + 1'b1));

  // R5: a missing enable holds the count
  a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(enable_p && enable_t)) |=> $stable(count));

  // R6: all ones wraps to zero
  a_r6_wrap: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && enable_p && enable_t && (&count)) |=> count == '0);

  // R7: carry needs enable_t and implies the terminal value
  a_r7_carry_gate: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (enable_t && (&count)));

  a_r7_carry_rise: assert property (@(posedge clk) disable iff (!clr_n)
    (enable_t && (&count)) |-> carry_out);

endmodule

bind casc_counter casc_counter_chk #(.CW(CNT_W)) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .load_n   (load_n),
  .enable_p (enable_p),
  .enable_t (enable_t),
  .data     (data),
  .count    (count),
  .carry_out(carry_out)
);

// File: tb/sim_casc_counter.sv
`timescale 1ns/1ps
module sim_casc_counter;

  localparam int W   = 8;
  localparam int MOD = 1 << W;
  localparam int MAXV = MOD - 1;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         load_n = 1'b1;
  logic         enable_p = 1'b0;
  logic         enable_t = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] count;
  logic         carry_out;

  int checks = 0;
  int errors = 0;
  int model = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  casc_counter u0 (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .enable_p (enable_p),
    .enable_t (enable_t),
    .data     (data),
    .count    (count),
    .carry_out(carry_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_carry();
    return (enable_t && model == MAXV) ? 1 : 0;
  endfunction

  // one clock: update the behavioural model, then compare away from the edge
  task automatic tick(input string req);
    @(posedge clk);
    if (!clr_n)                    model = 0;
    else if (!load_n)              model = int'(data);
    else if (enable_p && enable_t) model = (model + 1) % MOD;
    #1;
    chk(req, int'(count), model);
    chk({req, " carry"}, int'(carry_out), exp_carry());
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state
    repeat (3) tick("R1");
    #1 clr_n = 1'b1;

    // R3: load with both enables low
    data = 8'h0D; load_n = 1'b0;
    tick("R3");
    chk("R3 load 0x0D", int'(count), 8'h0D);
    load_n = 1'b1;

    // R4 and R8: count 0D,0E,0F,10,11
    enable_p = 1'b1; enable_t = 1'b1;
    repeat (4) tick("R4");
    chk("R8 nibble carry", int'(count), 8'h11);

    // R5: enable_p low holds, enable_t low holds
    enable_p = 1'b0;
    repeat (3) tick("R5");
    chk("R5 hold p-low", int'(count), 8'h11);
    enable_p = 1'b1; enable_t = 1'b0;
    repeat (3) tick("R5");
    chk("R5 hold t-low", int'(count), 8'h11);

    // R8: 0xEF -> 0xF0
    data = 8'hEF; load_n = 1'b0; tick("R3");
    load_n = 1'b1; enable_t = 1'b1;
    tick("R8");
    chk("R8 0xEF step", int'(count), 8'hF0);

    // R7: carry at all ones, gated only by enable_t
    data = 8'hFF; load_n = 1'b0; enable_p = 1'b0; enable_t = 1'b1;
    tick("R3");
    load_n = 1'b1;
    #1 chk("R7 carry high with p low", int'(carry_out), 1);
    enable_t = 1'b0;
    #1 chk("R7 carry follows t", int'(carry_out), 0);
    enable_p = 1'b1;
    #1 chk("R7 carry still low", int'(carry_out), 0);
    tick("R5");
    chk("R5 hold at max", int'(count), 8'hFF);
    enable_t = 1'b1;
    #1 chk("R7 carry rises with t", int'(carry_out), 1);

    // R6: wrap to zero
    tick("R6");
    chk("R6 wrap", int'(count), 0);

    // R3: load beats counting
    data = 8'h42; load_n = 1'b0;
    tick("R3");
    chk("R3 load priority", int'(count), 8'h42);
    load_n = 1'b1;
    repeat (5) tick("R4");

    // R1: asynchronous clear mid-cycle
    #2 clr_n = 1'b0;
    #1 chk("R1 async clear", int'(count), 0);
    model = 0;
    // R2: clear overrides a pending load and count
    data = 8'h99; load_n = 1'b0;
    tick("R2");
    chk("R2 clear over load", int'(count), 0);
    load_n = 1'b1;
    tick("R2");
    chk("R2 clear over count", int'(count), 0);
    #2 clr_n = 1'b1;

    // R4/R6/R8: long run through the full wrap, occasional enable gaps
    for (int i = 0; i < 600; i++) begin
      enable_p = (i % 37) != 5;
      enable_t = (i % 53) != 7;
      tick("R4");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule